// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events from on-chip sources and stores each one in a circular buffer in system memory. Every event becomes a 16-byte vector of four 32-bit words. The words go out as single-word memory writes over a valid/ready handshake. Software drains the buffer by reading vectors and then moving a read pointer that the block holds in a register. The block keeps a byte-granular write pointer. An interrupt line stays high while the ring holds unread vectors.

When a new vector would bring the write pointer onto the read pointer, the ring has overflowed. The block still writes that vector over the oldest entry and advances. If overflow detection is enabled, it also sets a sticky flag in bit 0 of the write-pointer value. Software clears the flag by writing 1 to a clear bit. The block can optionally copy the write-pointer value, flag included, to a 40-bit memory address after each vector. Software can then poll memory instead of the register.

Top module: `iv_ring_writer`

## Requirements
- R1: After reset, both pointers read 0, the control register reads 0, the overflow flag is clear, and `irqOut`, `busy`, `evtReady` and `memValid` are all low.
- R2: The four words of a vector are written in this order: word 0 = {24'b0, source id}, word 1 = {4'b0, 28-bit source data}, word 2 = {16-bit address-space id, 8-bit VM id, 8-bit ring id} (ring id in bits 7:0), word 3 = 0.
- R3: The write pointer changes only on the cycle that the fourth word is accepted, or on a host write. On that cycle it becomes (wptr + 16) & (4·2^size − 1), so it wraps to 0 at the ring end.
- R4: With detection on (control bit 2), a vector whose new write pointer equals the masked read pointer is still written and still advances the pointer. It also sets the flag, which reads as bit 0 of the write-pointer register and stays set over later vectors.
- R5: Writing the control register with bit 4 set clears the flag. That bit reads back 0. With detection off, an overflow leaves the flag clear.
- R6: When writeback is on (control bit 3), each vector is followed by one extra memory write. Its data is the updated write-pointer register value, and its address is {write-back high register bits 7:0, write-back low register}.
- R7: While the ring enable (control bit 0) is 0, `evtReady` stays low and no memory write starts. Host writes to the pointer registers take effect, and writing 0 to both reads back 0.
- R8: `irqOut` is high exactly when the ring enable is 1, the interrupt enable (control bit 1) is 1, and the read and write pointers differ. The flag is not part of that comparison.
- R9: `busy` is high from the accepted event until its last memory write is accepted. While `memValid` is high and `memReady` is low, `memValid`, `memAddr` and `memData` hold.
- R10: Word k of a vector goes to {base register, 8'h00} + (wptr & mask) + 4k, with k from 0 to 3.
- R11: The register offsets are 0 control, 1 base (address bits 39:8), 2 write-back low, 3 write-back high, 4 read pointer and 5 write pointer. Control bits 12:8 hold log2 of the ring size in 32-bit words. Pointer writes clear bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event offered |
| evtReady | output | 1 | Event accepted this cycle when high with evtValid |
| evtSrcId | input | 8 | Source id |
| evtSrcData | input | 28 | Source data |
| evtRingId | input | 8 | Ring id |
| evtVmId | input | 8 | VM id |
| evtPasId | input | 16 | Address-space id |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 3 | Host register offset |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Value of the addressed register |
| memValid | output | 1 | Memory word write request |
| memReady | input | 1 | Memory accepts the word |
| memAddr | output | 40 | Byte address of the word |
| memData | output | 32 | Word data |
| irqOut | output | 1 | Ring non-empty interrupt |
| busy | output | 1 | Vector or writeback transfer in flight |

## Verification
Events go in with distinct field values, so a swapped or truncated field in any of the three packed words shows up in the beat data. The ring is kept to four vector slots. The write pointer is driven through a wrap, and the read pointer is parked where the writer lands on it. That separates correct wrap masking from an off-by-one vector, and it also shows a sticky flag apart from one that tracks each vector. A writeback run under an alternating memory-ready pattern checks that the fifth beat carries the updated pointer. Runs with detection off and with the interrupt enable cleared show that each control bit gates only its own effect.

// File: rtl/iv_ring_pkg.sv
package iv_ring_pkg;
  localparam int ADDR_W = 40;
  localparam int WORDS = 4;
  localparam int IDX_W = $clog2(WORDS);
  localparam int VEC_BYTES = WORDS * 4;
  localparam int SIZE_W = 5;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] REG_BASE = 3'd1;
  localparam logic [REG_AW-1:0] REG_WBLO = 3'd2;
  localparam logic [REG_AW-1:0] REG_WBHI = 3'd3;
  localparam logic [REG_AW-1:0] REG_RPTR = 3'd4;
  localparam logic [REG_AW-1:0] REG_WPTR = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_WB   = 2'd2
  } ringState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             takeEvt;
    logic             commit;
    logic             wbSel;
    logic [IDX_W-1:0] wordIdx;
  } ringStb_t;
endpackage

// File: rtl/iv_ring_ctrl.sv
module iv_ring_ctrl
  import iv_ring_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ringEn,
  input  logic     wbEn,
  input  logic     evtValid,
  input  logic     memReady,
  output logic     evtReady,
  output logic     memValid,
  output logic     busy,
  output ringStb_t stb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  ringState_e state;
  logic [IDX_W-1:0] idx;

  always_comb begin
    evtReady    = (state == ST_IDLE) && ringEn;
    memValid    = (state != ST_IDLE);
    busy        = (state != ST_IDLE);
    stb.takeEvt = evtReady && evtValid;
    stb.commit  = (state == ST_BEAT) && memReady && (idx == LAST_IDX);
    stb.wbSel   = (state == ST_WB);
    stb.wordIdx = idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (stb.takeEvt) begin
            state <= ST_BEAT;
            idx   <= '0;
          end
        end
        ST_BEAT: begin
          if (memReady) begin
            if (idx == LAST_IDX) begin
              state <= wbEn ? ST_WB : ST_IDLE;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_WB: begin
          if (memReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iv_ring_dp.sv
module iv_ring_dp
  import iv_ring_pkg::*;
#(
  parameter int PTR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ringStb_t          stb,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [7:0]        evtSrcId,
  input  logic [27:0]       evtSrcData,
  input  logic [7:0]        evtRingId,
  input  logic [7:0]        evtVmId,
  input  logic [15:0]       evtPasId,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              irqOut,
  output logic              ringEn,
  output logic              wbEn,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  rptr,
  output logic              ovfFlag,
  output logic              ovfClr,
  output logic              hostWptrWr
);
  localparam int ALIGN_W = $clog2(VEC_BYTES);

  function automatic logic [PTR_W-1:0] sizeMask(input logic [SIZE_W-1:0] f);
    logic [33:0] m;
    m = (34'd4 << f) - 34'd1;
    return m[PTR_W-1:0];
  endfunction

  function automatic logic [PTR_W-1:0] alignPtr(input logic [PTR_W-1:0] p);
    return {p[PTR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  endfunction

  logic              irqEn, ovfDetEn;
  logic [SIZE_W-1:0] sizeLog2;
  logic [31:0]       baseHi, wbLo;
  logic [7:0]        wbHi;
  logic [7:0]        srcQ, ringQ, vmQ;
  logic [27:0]       dataQ;
  logic [15:0]       pasQ;

  logic wrCtrl, wrBase, wrWbLo, wrWbHi, wrRptr;
  logic [PTR_W-1:0] ptrMask, nextWptr, ringOff;
  logic             wouldPass;
  logic [31:0]      wptrWord;
  logic [ADDR_W-1:0] ringAddr;
  logic [WORDS-1:0][31:0] vecWord;
  logic [ADDR_W-1:0] wordAddr [WORDS];

  always_comb begin
    wrCtrl     = regWrEn && (regAddr == REG_CTRL);
    wrBase     = regWrEn && (regAddr == REG_BASE);
    wrWbLo     = regWrEn && (regAddr == REG_WBLO);
    wrWbHi     = regWrEn && (regAddr == REG_WBHI);
    wrRptr     = regWrEn && (regAddr == REG_RPTR);
    hostWptrWr = regWrEn && (regAddr == REG_WPTR);
    ovfClr     = wrCtrl && regWrData[4];
  end

  always_comb begin
    ptrMask   = sizeMask(sizeLog2);
    ringOff   = wptr & ptrMask;
    nextWptr  = (wptr + PTR_W'(VEC_BYTES)) & ptrMask;
    wouldPass = (nextWptr == (rptr & ptrMask));
    wptrWord  = 32'({wptr[PTR_W-1:1], ovfFlag});
    ringAddr  = {baseHi, 8'h00} + ADDR_W'(ringOff);
  end

  // vector packing
  always_comb begin
    vecWord[0] = {24'b0, srcQ};
    vecWord[1] = {4'b0, dataQ};
    vecWord[2] = {pasQ, vmQ, ringQ};
    vecWord[3] = 32'b0;
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_wordAddr
    assign wordAddr[k] = ringAddr + ADDR_W'(4 * k);
  end

  always_comb begin
    if (stb.wbSel) begin
      memAddr = {wbHi, wbLo};
      memData = wptrWord;
    end else begin
      memAddr = wordAddr[stb.wordIdx];
      memData = vecWord[stb.wordIdx];
    end
  end

  always_comb begin
    case (regAddr)
      REG_CTRL: regRdData = 32'({sizeLog2, 8'({wbEn, ovfDetEn, irqEn, ringEn})});
      REG_BASE: regRdData = baseHi;
      REG_WBLO: regRdData = wbLo;
      REG_WBHI: regRdData = 32'(wbHi);
      REG_RPTR: regRdData = 32'(rptr);
      REG_WPTR: regRdData = wptrWord;
      default:  regRdData = 32'b0;
    endcase
  end

  assign irqOut = ringEn && irqEn && (rptr != wptr);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ringEn   <= 1'b0;
      irqEn    <= 1'b0;
      ovfDetEn <= 1'b0;
      wbEn     <= 1'b0;
      sizeLog2 <= '0;
      baseHi   <= '0;
      wbLo     <= '0;
      wbHi     <= '0;
    end else begin
      if (wrCtrl) begin
        ringEn   <= regWrData[0];
        irqEn    <= regWrData[1];
        ovfDetEn <= regWrData[2];
        wbEn     <= regWrData[3];
        sizeLog2 <= regWrData[8 +: SIZE_W];
      end
      if (wrBase) baseHi <= regWrData;
      if (wrWbLo) wbLo <= regWrData;
      if (wrWbHi) wbHi <= regWrData[7:0];
    end
  end

  // pointers and overflow flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr    <= '0;
      wptr    <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (wrRptr) rptr <= alignPtr(regWrData[PTR_W-1:0]);
      if (stb.commit) wptr <= nextWptr;
      if (hostWptrWr) wptr <= alignPtr(regWrData[PTR_W-1:0]);
      if (ovfClr) ovfFlag <= 1'b0;
      if (stb.commit && ovfDetEn && wouldPass) ovfFlag <= 1'b1;
    end
  end

  // event capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcQ  <= '0;
      dataQ <= '0;
      ringQ <= '0;
      vmQ   <= '0;
      pasQ  <= '0;
    end else if (stb.takeEvt) begin
      srcQ  <= evtSrcId;
      dataQ <= evtSrcData;
      ringQ <= evtRingId;
      vmQ   <= evtVmId;
      pasQ  <= evtPasId;
    end
  end
endmodule

// File: rtl/iv_ring_writer.sv
module iv_ring_writer
  import iv_ring_pkg::*;
#(
  parameter int PTR_W = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evtValid,
  output logic        evtReady,
  input  logic [7:0]  evtSrcId,
  input  logic [27:0] evtSrcData,
  input  logic [7:0]  evtRingId,
  input  logic [7:0]  evtVmId,
  input  logic [15:0] evtPasId,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memValid,
  input  logic        memReady,
  output logic [39:0] memAddr,
  output logic [31:0] memData,
  output logic        irqOut,
  output logic        busy
);
  ringStb_t         stb;
  logic             ringEnW, wbEnW, ovfFlagW, ovfClrW, hostWptrWrW;
  logic [PTR_W-1:0] wptrW, rptrW;

  iv_ring_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ringEn   (ringEnW),
    .wbEn     (wbEnW),
    .evtValid (evtValid),
    .memReady (memReady),
    .evtReady (evtReady),
    .memValid (memValid),
    .busy     (busy),
    .stb      (stb)
  );

  iv_ring_dp #(.PTR_W(PTR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .evtSrcId   (evtSrcId),
    .evtSrcData (evtSrcData),
    .evtRingId  (evtRingId),
    .evtVmId    (evtVmId),
    .evtPasId   (evtPasId),
    .memAddr    (memAddr),
    .memData    (memData),
    .irqOut     (irqOut),
    .ringEn     (ringEnW),
    .wbEn       (wbEnW),
    .wptr       (wptrW),
    .rptr       (rptrW),
    .ovfFlag    (ovfFlagW),
    .ovfClr     (ovfClrW),
    .hostWptrWr (hostWptrWrW)
  );
endmodule

// File: rtl/iv_ring_chk.sv
module iv_ring_chk #(
  parameter int PTR_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             memValid,
  input logic             memReady,
  input logic [39:0]      memAddr,
  input logic [31:0]      memData,
  input logic             evtReady,
  input logic             irqOut,
  input logic             ringEn,
  input logic [PTR_W-1:0] wptr,
  input logic [PTR_W-1:0] rptr,
  input logic             ovfFlag,
  input logic             ovfClr,
  input logic             commit,
  input logic             hostWptrWr
);
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));

  p_commit_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> memValid && memReady);

  p_wptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit && !hostWptrWr |=> $stable(wptr));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovfFlag && !ovfClr |=> ovfFlag);

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovfClr && !commit |=> !ovfFlag);

  p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ringEn |-> !evtReady);

  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr == rptr) |-> !irqOut);
endmodule

bind iv_ring_writer iv_ring_chk #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .memValid   (memValid),
  .memReady   (memReady),
  .memAddr    (memAddr),
  .memData    (memData),
  .evtReady   (evtReady),
  .irqOut     (irqOut),
  .ringEn     (ringEnW),
  .wptr       (wptrW),
  .rptr       (rptrW),
  .ovfFlag    (ovfFlagW),
  .ovfClr     (ovfClrW),
  .commit     (stb.commit),
  .hostWptrWr (hostWptrWrW)
);

// File: tb/iv_ring_writer_bench.sv
module iv_ring_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [39:0] BASE_ADDR = 40'h0001234500;
  localparam logic [39:0] WB_ADDR = 40'hA500008000;
  // {src8, data28, ring8, vm8, pas16, expected wptr read 20, expected irq 1}
  localparam logic [88:0] TAB [8] = '{
    {8'h11, 28'h1234567, 8'h01, 8'h02, 16'hBEEF, 20'd16, 1'b1},
    {8'hA2, 28'hFEDCBA9, 8'h7F, 8'h80, 16'h0001, 20'd32, 1'b1},
    {8'h3C, 28'h0000001, 8'hFF, 8'h00, 16'hFFFF, 20'd48, 1'b1},
    {8'h44, 28'h5A5A5A5, 8'h10, 8'h20, 16'h3030, 20'd0,  1'b1},
    {8'h55, 28'hA5A5A5A, 8'h11, 8'h21, 16'h3131, 20'd16, 1'b1},
    {8'h66, 28'h0F0F0F0, 8'h12, 8'h22, 16'h3232, 20'd32, 1'b1},
    {8'h77, 28'hF0F0F0F, 8'h13, 8'h23, 16'h3333, 20'd49, 1'b0},
    {8'h88, 28'h1111111, 8'h14, 8'h24, 16'h3434, 20'd1,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evtValid = 1'b0;
  logic evtReady;
  logic [7:0] evtSrcId = '0;
  logic [27:0] evtSrcData = '0;
  logic [7:0] evtRingId = '0;
  logic [7:0] evtVmId = '0;
  logic [15:0] evtPasId = '0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memValid;
  logic memReady = 1'b1;
  logic [39:0] memAddr;
  logic [31:0] memData;
  logic irqOut, busy;

  int total = 0;
  int bad = 0;
  bit stall = 1'b0;
  int logN = 0;
  logic [39:0] logA [256];
  logic [31:0] logD [256];

  iv_ring_writer u_iv_ring_writer (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtReady(evtReady),
    .evtSrcId(evtSrcId), .evtSrcData(evtSrcData), .evtRingId(evtRingId),
    .evtVmId(evtVmId), .evtPasId(evtPasId), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .irqOut(irqOut), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // memory model: log accepted beats, then drive next ready
  always @(negedge clk) begin
    if (memValid && memReady && logN < 256) begin
      logA[logN] = memAddr;
      logD[logN] = memData;
      logN = logN + 1;
    end
    memReady = stall ? ~memReady : 1'b1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic sendEvt(input logic [67:0] f, input string tag);
    @(negedge clk);
    {evtSrcId, evtSrcData, evtRingId, evtVmId, evtPasId} = f;
    evtValid = 1'b1;
    while (!evtReady) @(negedge clk);
    @(negedge clk);
    evtValid = 1'b0;
    chk({tag, " R9 busy after accept"}, 64'(busy), 64'd1);
    while (busy) @(negedge clk);
  endtask

  task automatic checkVec(input int s, input logic [19:0] off, input logic [67:0] f,
                          input string tag);
    logic [31:0] w [4];
    w[0] = {24'b0, f[67:60]};
    w[1] = {4'b0, f[59:32]};
    w[2] = {f[15:0], f[23:16], f[31:24]};
    w[3] = 32'b0;
    for (int k = 0; k < 4; k++) begin
      chk({tag, " R10 addr"}, 64'(logA[s + k]), 64'(BASE_ADDR + 40'(off) + 40'(4 * k)));
      chk({tag, " R2 data"}, 64'(logD[s + k]), 64'(w[k]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [19:0] off;
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    regRead(3'd5, v); chk("R1 wptr", 64'(v), 64'd0);
    regRead(3'd4, v); chk("R1 rptr", 64'(v), 64'd0);
    regRead(3'd0, v); chk("R1 ctrl", 64'(v), 64'd0);
    chk("R1 irq", 64'(irqOut), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 evtReady", 64'(evtReady), 64'd0);
    chk("R1 memValid", 64'(memValid), 64'd0);

    // R7 ring disabled ignores events
    @(negedge clk);
    evtValid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 evtReady off", 64'(evtReady), 64'd0);
    evtValid = 1'b0;
    chk("R7 no beats", 64'(logN), 64'd0);

    // R11 configuration: 16-word ring (64 bytes), ring+irq+detect on
    regWrite(3'd1, 32'h00012345);
    regWrite(3'd2, 32'h00008000);
    regWrite(3'd3, 32'h000000A5);
    regWrite(3'd0, 32'h00000407);
    regRead(3'd0, v); chk("R11 ctrl readback", 64'(v), 64'h407);

    off = 20'd0;
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin
        regWrite(3'd4, 32'd48);
        chk("R8 irq low when rptr==wptr", 64'(irqOut), 64'd0);
      end
      s = logN;
      sendEvt(TAB[i][88:21], "table");
      chk("R3 beat count", 64'(logN - s), 64'd4);
      checkVec(s, off, TAB[i][88:21], "table");
      regRead(3'd5, v);
      chk("R3 R4 wptr read", 64'(v), 64'(TAB[i][20:1]));
      chk("R8 irq after vector", 64'(irqOut), 64'(TAB[i][0]));
      off = (off + 20'd16) & 20'd63;
    end

    // R5 clear flag
    regWrite(3'd0, 32'h00000417);
    regRead(3'd5, v); chk("R5 flag cleared", 64'(v), 64'd0);
    regRead(3'd0, v); chk("R5 clear bit reads 0", 64'(v), 64'h407);

    // R8 interrupt enable gating (wptr 0, rptr 48)
    regWrite(3'd0, 32'h00000405);
    chk("R8 irqEn off", 64'(irqOut), 64'd0);
    regWrite(3'd0, 32'h00000407);
    chk("R8 irqEn on", 64'(irqOut), 64'd1);

    // R6 writeback with stalled memory (R9)
    stall = 1'b1;
    regWrite(3'd0, 32'h0000040F);
    s = logN;
    sendEvt({8'h99, 28'hC0FFEE1, 8'h31, 8'h32, 16'h3334}, "wb");
    chk("R6 beat count", 64'(logN - s), 64'd5);
    checkVec(s, 20'd0, {8'h99, 28'hC0FFEE1, 8'h31, 8'h32, 16'h3334}, "wb R9");
    chk("R6 wb addr", 64'(logA[s + 4]), 64'(WB_ADDR));
    chk("R6 wb data", 64'(logD[s + 4]), 64'd16);
    stall = 1'b0;

    // R5 detection off: would-pass leaves flag clear
    regWrite(3'd4, 32'd32);
    regWrite(3'd0, 32'h00000403);
    sendEvt({8'hAB, 28'h0000ABC, 8'h41, 8'h42, 16'h4344}, "nodet");
    regRead(3'd5, v); chk("R5 no flag with detect off", 64'(v), 64'd32);
    chk("R8 irq equal ptrs", 64'(irqOut), 64'd0);

    // R7 disabled ring: pointer writes of 0 accepted, events ignored
    regWrite(3'd0, 32'h00000000);
    regWrite(3'd4, 32'd0);
    regWrite(3'd5, 32'd0);
    regRead(3'd4, v); chk("R7 rptr zeroed", 64'(v), 64'd0);
    regRead(3'd5, v); chk("R7 wptr zeroed", 64'(v), 64'd0);
    s = logN;
    @(negedge clk);
    evtValid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 evtReady off again", 64'(evtReady), 64'd0);
    evtValid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 no beats when off", 64'(logN - s), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule